// File: doc/BRIEF.md
# DSP Address Pointer Update Unit

This block holds one address pointer and works out its next value from the current pointer, a signed offset and a 16-bit modifier word. The modifier word picks the arithmetic. One value gives bit-reversed addition with the carry running from the most significant bit down, which is used to step through FFT data. A range of positive values gives modulo wrap inside a circular buffer. Values with the top bit set and all-ones low bits give multiple wrap-around modulo a power of two. All ones gives plain linear addition. Every other value with the top bit set is reserved.

The circular buffer's lower bound comes from the pointer itself. The low bits of the pointer that cover the modulus are cleared, so the buffer sits on an aligned boundary. The next value is shown on `ptr_next` in the same cycle. An update strobe copies it into the pointer register. A write strobe loads the pointer directly and wins when both strobes are high. A reserved modifier leaves the pointer as it was and raises a one-cycle error flag. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `agu_ptr_unit`

## Requirements
- R1: Asserting reset clears `ptr_q` and `bad_mod` at once. Both stay zero until two rising edges after reset is released.
- R2: With `wr_en` high, `ptr_q` takes `wr_data` at the next rising edge, whatever `upd_en` is. No error flag is raised in that cycle.
- R3: Modifier 0xFFFF gives `ptr_next = ptr_q + offset` modulo 2^16.
- R4: A modifier M in 0x0001..0x7FFF sets the modulus to M+1. The base is `ptr_q` with every bit up to and including the highest set bit of M cleared. Provided `ptr_q - base <= M` and the offset magnitude is at most M+1, `ptr_next` equals base plus ((ptr_q - base + offset) wrapped into 0..M).
- R5: A modifier 0x8000 + 2^k - 1, for k from 1 to 14, keeps bits 15..k of `ptr_q`. Bits k-1..0 become the low k bits of `ptr_q + offset`, so an offset larger than 2^k wraps more than once.
- R6: Modifier 0x0000 gives `ptr_next = rev(rev(ptr_q) + rev(offset))`, where rev mirrors bit i to bit 15-i.
- R7: Any other modifier with bit 15 set is reserved, including 0x8000. For a reserved modifier `ptr_next` equals `ptr_q`. An update with a reserved modifier leaves `ptr_q` unchanged and drives `bad_mod` high for exactly the one cycle after the update edge.
- R8: `ptr_next` follows the inputs in the same cycle. With `upd_en` high and `wr_en` low, `ptr_q` takes `ptr_next` at the next edge. With both strobes low, `ptr_q` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for the pointer register |
| wr_data | input | 16 | Value to load |
| upd_en | input | 1 | Update strobe: pointer takes `ptr_next` |
| offset | input | 16 | Signed two's-complement step |
| modifier | input | 16 | Arithmetic select word |
| ptr_q | output | 16 | Current pointer |
| ptr_next | output | 16 | Combinational next pointer |
| bad_mod | output | 1 | One-cycle pulse after an update with a reserved modifier |

## Verification
`ptr_next` is combinational. The bench changes the offset and modifier on a falling edge and reads `ptr_next` 2 ns later, before the next rising edge. `ptr_q` and `bad_mod` pass through a single register, so they are read at the falling edge that follows the rising edge on which the strobe was sampled. A second read one cycle later confirms that `bad_mod` has dropped. The bench waits three rising edges after releasing reset, which allows for the two-stage synchronizer, before it applies any strobe.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    MODE_REV  = 3'd0,
    MODE_MOD  = 3'd1,
    MODE_WRAP = 3'd2,
    MODE_LIN  = 3'd3,
    MODE_RSV  = 3'd4
  } mode_e;
endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/agu_mod_decode.sv
module agu_mod_decode
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] modifier,
  output mode_e         mode,
  output logic [AW-1:0] wrap_mask,
  output logic [AW-1:0] blk_mask
);
  localparam int LW = AW - 1;
  localparam logic [LW-1:0] LONE = {{(LW-1){1'b0}}, 1'b1};

  logic [LW-1:0] low;
  logic [LW-1:0] low_p1;
  logic          is_pow2m1;

  assign low    = modifier[LW-1:0];
  assign low_p1 = low + LONE;
  assign is_pow2m1 = (low != '0) && ((low & low_p1) == '0);

  // smallest all-ones value that covers the modifier
  always_comb begin
    blk_mask = modifier;
    for (int i = 1; i < AW; i++) begin
      blk_mask = blk_mask | (modifier >> i);
    end
  end

  assign wrap_mask = {1'b0, low};

  always_comb begin
    if (modifier == '0)          mode = MODE_REV;
    else if (&modifier)          mode = MODE_LIN;
    else if (!modifier[AW-1])    mode = MODE_MOD;
    else if (is_pow2m1)          mode = MODE_WRAP;
    else                         mode = MODE_RSV;
  end
endmodule

// File: rtl/agu_next_calc.sv
module agu_next_calc
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] modm1,
  input  mode_e         mode,
  input  logic [AW-1:0] wrap_mask,
  input  logic [AW-1:0] blk_mask,
  output logic [AW-1:0] nxt,
  output logic          rsv
);
  localparam int SW = AW + 2;
  localparam logic [SW-1:0] SONE = {{(SW-1){1'b0}}, 1'b1};

  // linear sum shared by linear and multiple-wrap modes
  logic [AW-1:0] lin_sum;
  assign lin_sum = ptr + offset;

  // reverse-carry path
  logic [AW-1:0] ptr_rev, off_rev, rev_sum, rev_res;
  for (genvar i = 0; i < AW; i++) begin : g_rev_in
    assign ptr_rev[i] = ptr[AW-1-i];
    assign off_rev[i] = offset[AW-1-i];
  end
  assign rev_sum = ptr_rev + off_rev;
  for (genvar i = 0; i < AW; i++) begin : g_rev_out
    assign rev_res[i] = rev_sum[AW-1-i];
  end

  // modulo path
  logic [AW-1:0]        base, lo;
  logic signed [SW-1:0] lo_ext, off_ext, mm1_ext, modulus, msum, mwrap;
  logic [AW-1:0]        mod_res;

  always_comb begin
    base    = ptr & ~blk_mask;
    lo      = ptr & blk_mask;
    lo_ext  = $signed({2'b00, lo});
    off_ext = $signed({{2{offset[AW-1]}}, offset});
    mm1_ext = $signed({2'b00, modm1});
    modulus = mm1_ext + $signed(SONE);
    msum    = lo_ext + off_ext;
    if (msum > mm1_ext)         mwrap = msum - modulus;
    else if (msum < $signed('0)) mwrap = msum + modulus;
    else                        mwrap = msum;
    mod_res = base + mwrap[AW-1:0];
  end

  // result select
  always_comb begin
    rsv = 1'b0;
    unique case (mode)
      MODE_REV:  nxt = rev_res;
      MODE_MOD:  nxt = mod_res;
      MODE_WRAP: nxt = (ptr & ~wrap_mask) | (lin_sum & wrap_mask);
      MODE_LIN:  nxt = lin_sum;
      default: begin
        nxt = ptr;
        rsv = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/agu_ptr_unit.sv
module agu_ptr_unit
  import agu_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] modifier,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr_next,
  output logic          bad_mod
);
  logic          rst_s;
  mode_e         mode;
  logic [AW-1:0] wrap_mask, blk_mask;
  logic          rsv;
  logic [AW-1:0] ptr_d;
  logic          bad_d;
  logic          ptr_en;

  agu_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  agu_mod_decode #(.AW(AW)) decode_i (
    .modifier  (modifier),
    .mode      (mode),
    .wrap_mask (wrap_mask),
    .blk_mask  (blk_mask)
  );

  agu_next_calc #(.AW(AW)) calc_i (
    .ptr       (ptr_q),
    .offset    (offset),
    .modm1     (modifier),
    .mode      (mode),
    .wrap_mask (wrap_mask),
    .blk_mask  (blk_mask),
    .nxt       (ptr_next),
    .rsv       (rsv)
  );

  // next-state
  always_comb begin
    ptr_en = wr_en | upd_en;
    ptr_d  = wr_en ? wr_data : ptr_next;
    bad_d  = upd_en & ~wr_en & rsv;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) bad_mod <= 1'b0;
    else        bad_mod <= bad_d;
  end
endmodule

// File: rtl/agu_ptr_unit_chk.sv
module agu_ptr_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_data,
  input logic          upd_en,
  input logic [AW-1:0] offset,
  input logic [AW-1:0] modifier,
  input logic [AW-1:0] ptr_q,
  input logic [AW-1:0] ptr_next,
  input logic          bad_mod
);
  p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr_q == $past(wr_data)) && !bad_mod);

  p_update_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en) |=> ptr_q == $past(ptr_next));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !wr_en) |=> $stable(ptr_q));

  p_linear_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&modifier) |-> ptr_next == ptr_q + offset);

  p_wrap_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (modifier[AW-1] && modifier[0] && !(&modifier)) |->
      ((ptr_next ^ ptr_q) & ~{1'b0, modifier[AW-2:0]}) == '0);

  p_bad_after_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mod |-> $past(upd_en) && !$past(wr_en) && $past(modifier[AW-1]));

  p_bad_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mod |-> ptr_q == $past(ptr_q));
endmodule

bind agu_ptr_unit agu_ptr_unit_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_s),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .upd_en   (upd_en),
  .offset   (offset),
  .modifier (modifier),
  .ptr_q    (ptr_q),
  .ptr_next (ptr_next),
  .bad_mod  (bad_mod)
);

// File: tb/agu_ptr_unit_tb_top.sv
`timescale 1ns/1ps
module agu_ptr_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        upd_en;
  logic [15:0] offset;
  logic [15:0] modifier;
  logic [15:0] ptr_q;
  logic [15:0] ptr_next;
  logic        bad_mod;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  agu_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .upd_en(upd_en), .offset(offset), .modifier(modifier),
    .ptr_q(ptr_q), .ptr_next(ptr_next), .bad_mod(bad_mod)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {bad, ptr, offset, modifier, expected}
  localparam int NV = 21;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 16'h1234, 16'h0010, 16'hFFFF, 16'h1244},
    {1'b0, 16'hFFF0, 16'h0020, 16'hFFFF, 16'h0010},
    {1'b0, 16'h0005, 16'hFFFE, 16'hFFFF, 16'h0003},
    {1'b0, 16'h0108, 16'h0003, 16'h0009, 16'h0101},
    {1'b0, 16'h0101, 16'hFFFD, 16'h0009, 16'h0108},
    {1'b0, 16'h0105, 16'h0002, 16'h0009, 16'h0107},
    {1'b0, 16'h0109, 16'h0001, 16'h0009, 16'h0100},
    {1'b0, 16'h2006, 16'h0003, 16'h0007, 16'h2001},
    {1'b0, 16'h0030, 16'h0011, 16'h0010, 16'h0030},
    {1'b0, 16'h8005, 16'hFFF0, 16'h7FFF, 16'hFFF5},
    {1'b0, 16'h1236, 16'h000B, 16'h8007, 16'h1231},
    {1'b0, 16'h12F0, 16'h0020, 16'h80FF, 16'h1210},
    {1'b0, 16'h1231, 16'hFFFE, 16'h8007, 16'h1237},
    {1'b0, 16'hFFFF, 16'h0001, 16'hBFFF, 16'hC000},
    {1'b0, 16'h0000, 16'h8000, 16'h0000, 16'h8000},
    {1'b0, 16'h8000, 16'h8000, 16'h0000, 16'h4000},
    {1'b0, 16'hC000, 16'h8000, 16'h0000, 16'h2000},
    {1'b0, 16'h0004, 16'h0008, 16'h0000, 16'h000C},
    {1'b1, 16'h4321, 16'h0005, 16'h8000, 16'h4321},
    {1'b1, 16'h4321, 16'h0005, 16'h8005, 16'h4321},
    {1'b1, 16'h0777, 16'h0001, 16'h8002, 16'h0777}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [15:0] m, input logic b);
    if (b)            return "R7";
    if (m == 16'h0)   return "R6";
    if (&m)           return "R3";
    if (!m[15])       return "R4";
    return "R5";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; upd_en = 1'b0;
    wr_data = '0; offset = '0; modifier = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ptr after reset", ptr_q, 16'h0);
    chk("R1", "flag after reset", {15'd0, bad_mod}, 16'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr_en   = 1'b1; upd_en = 1'b0;
      wr_data = VEC[v][63:48];
      @(posedge clk); @(negedge clk);
      wr_en    = 1'b0;
      offset   = VEC[v][47:32];
      modifier = VEC[v][31:16];
      upd_en   = 1'b1;
      #2;
      chk(req_of(VEC[v][31:16], VEC[v][64]), "ptr_next same cycle R8",
          ptr_next, VEC[v][15:0]);
      @(posedge clk); @(negedge clk);
      upd_en = 1'b0;
      chk(req_of(VEC[v][31:16], VEC[v][64]), "ptr_q after update",
          ptr_q, VEC[v][15:0]);
      chk("R7", "error flag", {15'd0, bad_mod}, {15'd0, VEC[v][64]});
    end

    // R7 flag lasts exactly one cycle
    @(posedge clk); @(negedge clk);
    chk("R7", "flag dropped after one cycle", {15'd0, bad_mod}, 16'h0);

    // R8 hold with no strobe
    wr_en = 1'b1; wr_data = 16'h5A5A;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; modifier = 16'hFFFF; offset = 16'h0001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8", "hold without strobe", ptr_q, 16'h5A5A);

    // R2 write wins over update, no flag even with reserved modifier
    wr_en = 1'b1; upd_en = 1'b1; wr_data = 16'h0F0F; modifier = 16'h8000;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; upd_en = 1'b0;
    chk("R2", "write priority", ptr_q, 16'h0F0F);
    chk("R2", "no flag on write", {15'd0, bad_mod}, 16'h0);

    // R4 repeated stepping around a modulo-5 buffer
    modifier = 16'h0004; offset = 16'h0002; upd_en = 1'b1;
    wr_en = 1'b1; wr_data = 16'h0040;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    upd_en = 1'b0;
    chk("R4", "three steps of 2 mod 5", ptr_q, 16'h0041);

    // R1 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "async clear of ptr", ptr_q, 16'h0);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    upd_en = 1'b1; modifier = 16'hFFFF; offset = 16'h0003;
    @(posedge clk); @(negedge clk);
    chk("R1", "held during release", ptr_q, 16'h0);
    upd_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule